// File: doc/BRIEF.md
# Microcode Sequencer with Dispatch

This block is the control unit of a microcoded processor. It holds a 256-entry control store of 40-bit words, a small instruction register (function number and 16-bit literal) and a current-word register. When an instruction arrives, the next cycle addresses the store with the instruction's function number; the first 32 store locations therefore act as a dispatch table. From then on an external microprogram counter supplies the address. The cycle after the dispatch word is a branch slot. In that slot the sequencer issues no datapath control and tells the counter to increment.

Each active word is decoded into per-unit 4-bit control fields. The decoding depends on the word's store address: the lower half of the store uses a memory-oriented format and the upper half an arithmetic-oriented one. A condition field picks one of two registered ALU flags and decides whether the datapath fields are issued at all. The output field places the sign-extended literal, the constant one, or both onto two wired-OR buses, and passes the word's 8-bit operand to the counter. Any read of the top store location stops the sequencer until reset.

Top module: `ucode_sequencer`

## Requirements
- R1: While reset is asserted, every control field, both buses, `mpc_load`, `alt_fmt` and `halt` are zero.
- R2: When `instr_valid` is sampled high at an edge, the word at store address `instr_func` (zero-extended) is active after the following edge, with `ucode_addr` equal to the function number. The `mpc_addr` value offered in that cycle is ignored.
- R3: In the cycle after a dispatch word (the branch slot), all datapath fields, both buses and `mpc_load` are zero, and `mpc_ctl` is 4'b1011 (keep counter, add one, send result), whatever `mpc_valid` shows.
- R4: Outside dispatch and branch slot, a high `mpc_valid` at an edge makes the word at `mpc_addr` active after that edge. A low `mpc_valid` makes the active word all zero.
- R5: A new instruction takes priority: when `instr_valid` and `mpc_valid` are both high at an edge, the offered counter address is discarded and the outputs after that edge are zero.
- R6: Word bit field k is bits [4k+3:4k], and the operand is bits [39:32]. Words at addresses 0..127 drive field 5 to `dmem_ctl`, keep `alu_aux_ctl` zero and issue `alu_fn` as {0, field7[2:0]}. Words at 128..255 drive field 5 to `alu_aux_ctl`, keep `dmem_ctl` zero, issue all four bits of field 7 and raise `alt_fmt`.
- R7: Field 0: bit 0 drives the value 1 onto `bus2`, bit 1 drives the literal onto `bus1`, bit 2 drives the literal onto `bus2`, and bit 3 raises `mpc_load` with `mpc_operand` equal to the operand. Sources sharing a bus are ORed.
- R8: The 16-bit literal is sign-extended to 32 bits on both buses.
- R9: Field 1: bit 4 selects the zero flag, bit 5 the negative flag (both set: their OR). Bit 6 issues fields 2..7 when the selected condition holds, and bit 7 issues them when it does not. A suppressed field reads zero, and field 0 is never suppressed.
- R10: When neither bit 6 nor bit 7 is set, fields 2..7 are issued regardless of the flags.
- R11: The condition uses `alu_zero` and `alu_neg` as sampled at the edge that loaded the active word; later changes on those inputs do not alter the active outputs.
- R12: Reading address 255 through the counter path raises `halt` after that edge. `halt` stays high until reset, and afterwards no word is issued, including new instructions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | New instruction present this cycle |
| instr_func | input | 5 | Function number of the new instruction |
| instr_literal | input | 16 | Literal or address field of the new instruction |
| mpc_valid | input | 1 | Microprogram counter offers an address |
| mpc_addr | input | 8 | Address from the microprogram counter |
| alu_zero | input | 1 | ALU result was zero |
| alu_neg | input | 1 | ALU result was negative |
| cs_we | input | 1 | Control store write enable |
| cs_waddr | input | 8 | Control store write address |
| cs_wdata | input | 40 | Control store write word (operand in 39:32) |
| ucode_addr | output | 8 | Store address of the active word |
| alt_fmt | output | 1 | Active word uses the arithmetic-oriented format |
| mpc_load | output | 1 | Send operand to the counter |
| mpc_operand | output | 8 | Operand of the active word |
| mpc_ctl | output | 4 | Counter control field |
| pc_ctl | output | 4 | Program counter control field |
| reg_ctl | output | 4 | Register file control field |
| dmem_ctl | output | 4 | Data memory control field |
| alu_aux_ctl | output | 4 | ALU internal control field |
| alu_port_ctl | output | 4 | ALU input/output control field |
| alu_fn | output | 4 | ALU function |
| bus1 | output | 32 | Contribution to bus 1 |
| bus2 | output | 32 | Contribution to bus 2 |
| halt | output | 1 | Sequencer stopped |

## Verification
The hardest situations to reach are the collisions around dispatch. An instruction can arrive while the counter offers a valid address, and in the branch slot the counter still offers a stale address that must be ignored. The stimulus holds `mpc_valid` high with a real, non-zero word's address through the arrival, dispatch and slot cycles, so any leak of that word would show on the outputs. Flag timing is reached by changing the flag inputs between edges while a conditional word is active. The stop state is entered through address 255, then an instruction is offered to confirm it is refused.

// File: rtl/useq_pkg.sv
package useq_pkg;

    localparam int unsigned NIB_W = 4;

    // counter command issued during the branch slot: keep, add one, send back
    localparam logic [NIB_W-1:0] SLOT_CMD = 4'b1011;

    typedef enum logic [1:0] {
        RD_NONE,
        RD_DISPATCH,
        RD_SLOT,
        RD_MPC
    } rd_kind_e;

endpackage

// File: rtl/useq_store.sv
module useq_store #(
    parameter int unsigned AW     = 8,
    parameter int unsigned WORD_W = 40
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [WORD_W-1:0] rdata
);
    localparam int unsigned DEPTH = 1 << AW;

    logic [WORD_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];

endmodule

// File: rtl/useq_addr_sel.sv
module useq_addr_sel
    import useq_pkg::*;
#(
    parameter int unsigned AW   = 8,
    parameter int unsigned FN_W = 5
) (
    input  logic            instr_valid,
    input  logic            mpc_valid,
    input  logic [AW-1:0]   mpc_addr,
    input  logic            disp_q,
    input  logic            dword_q,
    input  logic            halt_q,
    input  logic [FN_W-1:0] func_q,
    output rd_kind_e        kind,
    output logic [AW-1:0]   rd_addr
);
    always_comb begin
        kind    = RD_NONE;
        rd_addr = mpc_addr;
        if (halt_q) begin
            kind = RD_NONE;
        end else if (instr_valid) begin
            // a fresh instruction wins; any counter address is dropped
            kind = RD_NONE;
        end else if (disp_q) begin
            kind    = RD_DISPATCH;
            rd_addr = AW'(func_q);
        end else if (dword_q) begin
            kind = RD_SLOT;
        end else if (mpc_valid) begin
            kind = RD_MPC;
        end
    end

endmodule

// File: rtl/useq_decode.sv
module useq_decode
    import useq_pkg::*;
#(
    parameter int unsigned UW_W   = 32,
    parameter int unsigned OPND_W = 8,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned LIT_W  = 16
) (
    input  logic [UW_W+OPND_W-1:0] cw,
    input  logic                   alt,
    input  logic                   slot,
    input  logic                   fz,
    input  logic                   fneg,
    input  logic [LIT_W-1:0]       literal,
    output logic                   mpc_load,
    output logic [OPND_W-1:0]      mpc_operand,
    output logic [NIB_W-1:0]       mpc_ctl,
    output logic [NIB_W-1:0]       pc_ctl,
    output logic [NIB_W-1:0]       reg_ctl,
    output logic [NIB_W-1:0]       dmem_ctl,
    output logic [NIB_W-1:0]       alu_aux_ctl,
    output logic [NIB_W-1:0]       alu_port_ctl,
    output logic [NIB_W-1:0]       alu_fn,
    output logic [DATA_W-1:0]      bus1,
    output logic [DATA_W-1:0]      bus2
);
    localparam int unsigned NIB_N  = UW_W / NIB_W;
    localparam int unsigned WORD_W = UW_W + OPND_W;

    logic [NIB_W-1:0]  nib   [NIB_N];
    logic [NIB_W-1:0]  gated [2:NIB_N-1];
    logic              cond;
    logic              issue;
    logic [DATA_W-1:0] lit_ext;

    for (genvar k = 0; k < NIB_N; k++) begin : g_split
        assign nib[k] = cw[k*NIB_W +: NIB_W];
    end

    always_comb begin
        cond  = (nib[1][0] & fz) | (nib[1][1] & fneg);
        issue = 1'b1;
        if (nib[1][2] | nib[1][3]) begin
            issue = (nib[1][2] & cond) | (nib[1][3] & ~cond);
        end
    end

    for (genvar k = 2; k < NIB_N; k++) begin : g_gate
        assign gated[k] = issue ? nib[k] : '0;
    end

    assign lit_ext = {{(DATA_W-LIT_W){literal[LIT_W-1]}}, literal};

    always_comb begin
        mpc_load     = nib[0][3];
        mpc_operand  = cw[WORD_W-1 -: OPND_W];
        mpc_ctl      = slot ? SLOT_CMD : gated[2];
        pc_ctl       = gated[3];
        reg_ctl      = gated[4];
        dmem_ctl     = alt ? '0 : gated[5];
        alu_aux_ctl  = alt ? gated[5] : '0;
        alu_port_ctl = gated[6];
        alu_fn       = alt ? gated[7] : {1'b0, gated[7][NIB_W-2:0]};
        bus1         = nib[0][1] ? lit_ext : '0;
        bus2         = (nib[0][0] ? DATA_W'(1) : '0) | (nib[0][2] ? lit_ext : '0);
    end

endmodule

// File: rtl/ucode_sequencer.sv
module ucode_sequencer
    import useq_pkg::*;
#(
    parameter int unsigned AW     = 8,
    parameter int unsigned UW_W   = 32,
    parameter int unsigned OPND_W = 8,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned LIT_W  = 16,
    parameter int unsigned FN_W   = 5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     instr_valid,
    input  logic [FN_W-1:0]          instr_func,
    input  logic [LIT_W-1:0]         instr_literal,
    input  logic                     mpc_valid,
    input  logic [AW-1:0]            mpc_addr,
    input  logic                     alu_zero,
    input  logic                     alu_neg,
    input  logic                     cs_we,
    input  logic [AW-1:0]            cs_waddr,
    input  logic [UW_W+OPND_W-1:0]   cs_wdata,
    output logic [AW-1:0]            ucode_addr,
    output logic                     alt_fmt,
    output logic                     mpc_load,
    output logic [OPND_W-1:0]        mpc_operand,
    output logic [3:0]               mpc_ctl,
    output logic [3:0]               pc_ctl,
    output logic [3:0]               reg_ctl,
    output logic [3:0]               dmem_ctl,
    output logic [3:0]               alu_aux_ctl,
    output logic [3:0]               alu_port_ctl,
    output logic [3:0]               alu_fn,
    output logic [DATA_W-1:0]        bus1,
    output logic [DATA_W-1:0]        bus2,
    output logic                     halt
);
    localparam int unsigned WORD_W   = UW_W + OPND_W;
    localparam logic [AW-1:0] STOP_A = '1;

    typedef struct packed {
        logic [FN_W-1:0]   func;
        logic [LIT_W-1:0]  lit;
        logic              disp;
        logic              dword;
        logic              slot;
        logic              live;
        logic [WORD_W-1:0] cw;
        logic [AW-1:0]     cw_addr;
        logic              halt;
        logic              fz;
        logic              fneg;
    } seq_state_t;

    seq_state_t        st_d, st_q;
    rd_kind_e          rd_kind;
    logic [AW-1:0]     rd_addr;
    logic [WORD_W-1:0] rd_data;
    logic              slot_now;

    useq_store #(.AW(AW), .WORD_W(WORD_W)) store_i (
        .clk   (clk),
        .we    (cs_we),
        .waddr (cs_waddr),
        .wdata (cs_wdata),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

    useq_addr_sel #(.AW(AW), .FN_W(FN_W)) sel_i (
        .instr_valid (instr_valid),
        .mpc_valid   (mpc_valid),
        .mpc_addr    (mpc_addr),
        .disp_q      (st_q.disp),
        .dword_q     (st_q.dword),
        .halt_q      (st_q.halt),
        .func_q      (st_q.func),
        .kind        (rd_kind),
        .rd_addr     (rd_addr)
    );

    always_comb begin
        st_d       = st_q;
        st_d.fz    = alu_zero;
        st_d.fneg  = alu_neg;
        st_d.cw    = '0;
        st_d.live  = 1'b0;
        st_d.dword = 1'b0;
        st_d.slot  = 1'b0;
        if (!st_q.halt && instr_valid) begin
            st_d.func = instr_func;
            st_d.lit  = instr_literal;
            st_d.disp = 1'b1;
        end
        case (rd_kind)
            RD_DISPATCH: begin
                st_d.cw      = rd_data;
                st_d.cw_addr = rd_addr;
                st_d.live    = 1'b1;
                st_d.dword   = 1'b1;
                st_d.disp    = 1'b0;
            end
            RD_SLOT: begin
                st_d.slot = 1'b1;
            end
            RD_MPC: begin
                st_d.cw      = rd_data;
                st_d.cw_addr = rd_addr;
                st_d.live    = 1'b1;
                if (rd_addr == STOP_A) begin
                    st_d.halt = 1'b1;
                end
            end
            default: begin
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign slot_now   = st_q.slot;
    assign ucode_addr = st_q.cw_addr;
    assign alt_fmt    = st_q.live & st_q.cw_addr[AW-1];
    assign halt       = st_q.halt;

    useq_decode #(
        .UW_W   (UW_W),
        .OPND_W (OPND_W),
        .DATA_W (DATA_W),
        .LIT_W  (LIT_W)
    ) dec_i (
        .cw           (st_q.cw),
        .alt          (alt_fmt),
        .slot         (st_q.slot),
        .fz           (st_q.fz),
        .fneg         (st_q.fneg),
        .literal      (st_q.lit),
        .mpc_load     (mpc_load),
        .mpc_operand  (mpc_operand),
        .mpc_ctl      (mpc_ctl),
        .pc_ctl       (pc_ctl),
        .reg_ctl      (reg_ctl),
        .dmem_ctl     (dmem_ctl),
        .alu_aux_ctl  (alu_aux_ctl),
        .alu_port_ctl (alu_port_ctl),
        .alu_fn       (alu_fn),
        .bus1         (bus1),
        .bus2         (bus2)
    );

endmodule

// File: rtl/useq_checker.sv
module useq_checker #(
    parameter int unsigned DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              instr_valid,
    input logic              halt,
    input logic              alt_fmt,
    input logic              slot_now,
    input logic              mpc_load,
    input logic [3:0]        mpc_ctl,
    input logic [3:0]        pc_ctl,
    input logic [3:0]        reg_ctl,
    input logic [3:0]        dmem_ctl,
    input logic [3:0]        alu_aux_ctl,
    input logic [3:0]        alu_fn,
    input logic [DATA_W-1:0] bus1,
    input logic [DATA_W-1:0] bus2
);
    assert_slot_inc_R3: assert property (@(posedge clk) disable iff (!rst_n)
        slot_now |-> (mpc_ctl == 4'b1011 && pc_ctl == 4'h0 && reg_ctl == 4'h0
                      && bus1 == '0 && bus2 == '0 && !mpc_load));

    assert_new_instr_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        instr_valid |=> (!mpc_load && mpc_ctl == 4'h0 && pc_ctl == 4'h0 && bus2 == '0));

    assert_mem_format_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !alt_fmt |-> (alu_aux_ctl == 4'h0 && !alu_fn[3]));

    assert_alu_format_R6: assert property (@(posedge clk) disable iff (!rst_n)
        alt_fmt |-> dmem_ctl == 4'h0);

    assert_halt_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> halt);

    assert_halt_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && $past(halt)) |-> (pc_ctl == 4'h0 && mpc_ctl == 4'h0
                                   && bus1 == '0 && bus2 == '0));

endmodule

bind ucode_sequencer useq_checker #(.DATA_W(DATA_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .instr_valid (instr_valid),
    .halt        (halt),
    .alt_fmt     (alt_fmt),
    .slot_now    (slot_now),
    .mpc_load    (mpc_load),
    .mpc_ctl     (mpc_ctl),
    .pc_ctl      (pc_ctl),
    .reg_ctl     (reg_ctl),
    .dmem_ctl    (dmem_ctl),
    .alu_aux_ctl (alu_aux_ctl),
    .alu_fn      (alu_fn),
    .bus1        (bus1),
    .bus2        (bus2)
);

// File: tb/ucode_sequencer_tb.sv
module ucode_sequencer_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        instr_valid;
    logic [4:0]  instr_func;
    logic [15:0] instr_literal;
    logic        mpc_valid;
    logic [7:0]  mpc_addr;
    logic        alu_zero;
    logic        alu_neg;
    logic        cs_we;
    logic [7:0]  cs_waddr;
    logic [39:0] cs_wdata;
    logic [7:0]  ucode_addr;
    logic        alt_fmt;
    logic        mpc_load;
    logic [7:0]  mpc_operand;
    logic [3:0]  mpc_ctl, pc_ctl, reg_ctl, dmem_ctl, alu_aux_ctl, alu_port_ctl, alu_fn;
    logic [31:0] bus1, bus2;
    logic        halt;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    ucode_sequencer dut_i (
        .clk (clk), .rst_n (rst_n),
        .instr_valid (instr_valid), .instr_func (instr_func), .instr_literal (instr_literal),
        .mpc_valid (mpc_valid), .mpc_addr (mpc_addr),
        .alu_zero (alu_zero), .alu_neg (alu_neg),
        .cs_we (cs_we), .cs_waddr (cs_waddr), .cs_wdata (cs_wdata),
        .ucode_addr (ucode_addr), .alt_fmt (alt_fmt),
        .mpc_load (mpc_load), .mpc_operand (mpc_operand),
        .mpc_ctl (mpc_ctl), .pc_ctl (pc_ctl), .reg_ctl (reg_ctl), .dmem_ctl (dmem_ctl),
        .alu_aux_ctl (alu_aux_ctl), .alu_port_ctl (alu_port_ctl), .alu_fn (alu_fn),
        .bus1 (bus1), .bus2 (bus2), .halt (halt)
    );

    typedef struct packed {
        logic [7:0]  addr;
        logic        z;
        logic        n;
        logic [3:0]  e_mpc, e_pc, e_reg, e_dmem, e_aux, e_io, e_fn;
        logic [31:0] e_b1, e_b2;
        logic        e_alt;
        logic [2:0]  tag;
    } vec_t;

    // tags: 0 R6 format, 1 R7 bus OR, 2 R8 sign extension, 3 R9 gating, 4 R10 unconditional
    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{8'h40, 1'b0, 1'b0, 4'h1, 4'h2, 4'h3, 4'h4, 4'h0, 4'h5, 4'h6, 32'h0,        32'h1,        1'b0, 3'd0},
        '{8'h41, 1'b0, 1'b0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 32'hFFFFFFF0, 32'hFFFFFFF0, 1'b0, 3'd2},
        '{8'h42, 1'b0, 1'b0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 32'h0,        32'hFFFFFFF1, 1'b0, 3'd1},
        '{8'hC0, 1'b0, 1'b0, 4'h1, 4'h2, 4'h3, 4'h0, 4'h4, 4'h5, 4'hE, 32'h0,        32'h0,        1'b1, 3'd0},
        '{8'h43, 1'b1, 1'b0, 4'h0, 4'hF, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 32'h0,        32'h1,        1'b0, 3'd3},
        '{8'h43, 1'b0, 1'b0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 32'h0,        32'h1,        1'b0, 3'd3},
        '{8'h44, 1'b0, 1'b1, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 32'h0,        32'h0,        1'b0, 3'd3},
        '{8'h44, 1'b0, 1'b0, 4'h0, 4'hA, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 32'h0,        32'h0,        1'b0, 3'd3},
        '{8'h45, 1'b0, 1'b0, 4'h0, 4'h7, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 32'h0,        32'h0,        1'b0, 3'd4},
        '{8'h45, 1'b1, 1'b1, 4'h0, 4'h7, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 32'h0,        32'h0,        1'b0, 3'd4}
    };

    function automatic string tag_name(input logic [2:0] t);
        case (t)
            3'd0:    return "R6";
            3'd1:    return "R7";
            3'd2:    return "R8";
            3'd3:    return "R9";
            default: return "R10";
        endcase
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    task automatic cycle(input logic iv, input logic mv, input logic [7:0] ma,
                         input logic z, input logic n);
        instr_valid = iv;
        mpc_valid   = mv;
        mpc_addr    = ma;
        alu_zero    = z;
        alu_neg     = n;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic put_word(input logic [7:0] a, input logic [39:0] w);
        cs_we    = 1'b1;
        cs_waddr = a;
        cs_wdata = w;
        @(posedge clk);
        @(negedge clk);
        cs_we = 1'b0;
    endtask

    initial begin
        #2000000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        finish_up();
    end

    initial begin
        rst_n = 1'b0;
        instr_valid = 1'b0; instr_func = 5'd0; instr_literal = 16'h0;
        mpc_valid = 1'b0; mpc_addr = 8'h0; alu_zero = 1'b0; alu_neg = 1'b0;
        cs_we = 1'b0; cs_waddr = 8'h0; cs_wdata = 40'h0;
        repeat (3) @(negedge clk);

        // R1: reset state
        check("R1", "bus1", bus1, 32'h0);
        check("R1", "bus2", bus2, 32'h0);
        check("R1", "mpc_ctl", {28'h0, mpc_ctl}, 32'h0);
        check("R1", "halt", {31'h0, halt}, 32'h0);
        check("R1", "alt_fmt", {31'h0, alt_fmt}, 32'h0);

        // store contents: operand in [39:32], field k in [4k+3:4k]
        put_word(8'h03, {8'h5A, 32'h0000_0408});
        put_word(8'h40, {8'h00, 32'hE543_2101});
        put_word(8'h41, {8'h00, 32'h0000_0006});
        put_word(8'h42, {8'h00, 32'h0000_0005});
        put_word(8'hC0, {8'h00, 32'hE543_2100});
        put_word(8'h43, {8'h00, 32'h0000_F051});
        put_word(8'h44, {8'h00, 32'h0000_A0A0});
        put_word(8'h45, {8'h00, 32'h0000_7010});
        put_word(8'hFF, {8'h00, 32'h0000_2000});
        rst_n = 1'b1;

        // R4: idle when no counter address
        cycle(1'b0, 1'b0, 8'h40, 1'b0, 1'b0);
        check("R4", "idle pc_ctl", {28'h0, pc_ctl}, 32'h0);
        check("R4", "idle bus2", bus2, 32'h0);

        // R5: instruction and counter address together, counter discarded
        instr_func    = 5'd3;
        instr_literal = 16'hFFF0;
        cycle(1'b1, 1'b1, 8'h40, 1'b0, 1'b0);
        check("R5", "pc_ctl", {28'h0, pc_ctl}, 32'h0);
        check("R5", "bus2", bus2, 32'h0);

        // R2: dispatch word from function number, counter address ignored
        cycle(1'b0, 1'b1, 8'h40, 1'b0, 1'b0);
        check("R2", "ucode_addr", {24'h0, ucode_addr}, 32'h3);
        check("R2", "mpc_ctl", {28'h0, mpc_ctl}, 32'h4);
        check("R7", "mpc_load", {31'h0, mpc_load}, 32'h1);
        check("R7", "mpc_operand", {24'h0, mpc_operand}, 32'h5A);
        check("R2", "pc_ctl", {28'h0, pc_ctl}, 32'h0);

        // R3: branch slot
        cycle(1'b0, 1'b1, 8'h40, 1'b0, 1'b0);
        check("R3", "mpc_ctl", {28'h0, mpc_ctl}, 32'hB);
        check("R3", "pc_ctl", {28'h0, pc_ctl}, 32'h0);
        check("R3", "bus2", bus2, 32'h0);
        check("R3", "mpc_load", {31'h0, mpc_load}, 32'h0);

        // R4 with R6..R10: table of counter-path reads
        for (int i = 0; i < NV; i++) begin
            cycle(1'b0, 1'b1, VECS[i].addr, VECS[i].z, VECS[i].n);
            check(tag_name(VECS[i].tag), "ucode_addr", {24'h0, ucode_addr}, {24'h0, VECS[i].addr});
            check(tag_name(VECS[i].tag), "mpc_ctl", {28'h0, mpc_ctl}, {28'h0, VECS[i].e_mpc});
            check(tag_name(VECS[i].tag), "pc_ctl", {28'h0, pc_ctl}, {28'h0, VECS[i].e_pc});
            check(tag_name(VECS[i].tag), "reg_ctl", {28'h0, reg_ctl}, {28'h0, VECS[i].e_reg});
            check(tag_name(VECS[i].tag), "dmem_ctl", {28'h0, dmem_ctl}, {28'h0, VECS[i].e_dmem});
            check(tag_name(VECS[i].tag), "alu_aux_ctl", {28'h0, alu_aux_ctl}, {28'h0, VECS[i].e_aux});
            check(tag_name(VECS[i].tag), "alu_port_ctl", {28'h0, alu_port_ctl}, {28'h0, VECS[i].e_io});
            check(tag_name(VECS[i].tag), "alu_fn", {28'h0, alu_fn}, {28'h0, VECS[i].e_fn});
            check(tag_name(VECS[i].tag), "bus1", bus1, VECS[i].e_b1);
            check(tag_name(VECS[i].tag), "bus2", bus2, VECS[i].e_b2);
            check(tag_name(VECS[i].tag), "alt_fmt", {31'h0, alt_fmt}, {31'h0, VECS[i].e_alt});
        end

        // R11: flags are taken at the loading edge only
        cycle(1'b0, 1'b1, 8'h43, 1'b1, 1'b0);
        check("R11", "pc_ctl before flag change", {28'h0, pc_ctl}, 32'hF);
        alu_zero = 1'b0;
        #1;
        check("R11", "pc_ctl after flag change", {28'h0, pc_ctl}, 32'hF);

        // R12: stop location
        cycle(1'b0, 1'b1, 8'hFF, 1'b0, 1'b0);
        check("R12", "halt", {31'h0, halt}, 32'h1);
        check("R12", "stop word pc_ctl", {28'h0, pc_ctl}, 32'h2);
        cycle(1'b0, 1'b1, 8'h40, 1'b0, 1'b0);
        check("R12", "halted pc_ctl", {28'h0, pc_ctl}, 32'h0);
        check("R12", "halted bus2", bus2, 32'h0);
        cycle(1'b1, 1'b1, 8'h40, 1'b0, 1'b0);
        cycle(1'b0, 1'b1, 8'h40, 1'b0, 1'b0);
        check("R12", "halted dispatch mpc_ctl", {28'h0, mpc_ctl}, 32'h0);
        check("R12", "halted dispatch load", {31'h0, mpc_load}, 32'h0);
        check("R12", "halt held", {31'h0, halt}, 32'h1);

        // R1: reset clears the stop state
        mpc_valid = 1'b0;
        rst_n = 1'b0;
        #1;
        check("R1", "halt cleared", {31'h0, halt}, 32'h0);
        check("R1", "pc_ctl cleared", {28'h0, pc_ctl}, 32'h0);

        finish_up();
    end

endmodule